// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block is a serial slave that loads a small bank of control registers from a host. The host drives three lines and a chip select. The shift clock moves one data bit per rising edge, most significant bit first. A falling edge on the latch line opens a word. The next rising edge on the latch line closes the word and commits it. Every 16-bit word carries its own 2-bit target address in bits 10:9. The address picks one of four registers: the left attenuation, the right attenuation, the general controls, and the format and filter controls.

All serial lines are sampled in the system clock domain through synchronizer stages. This works because every phase of the latch and shift lines lasts several system clocks. The decoded fields leave the block as parallel, registered outputs. A word that does not meet the framing rules leaves every register untouched. A word is rejected when it has a bit count other than sixteen, or when chip select is high at the closing latch edge.

Top module: `ctrl_serial_port`

## Requirements
- R1: After reset, both attenuation codes are 8'hFF and both load bits are 0. All general control bits are 0. The sample-rate select is 2'b10 (44.1 kHz). Every other format and filter bit is 0.
- R2: A committed word with bits 10:9 = 2'b00 loads the left channel. Bits 7:0 go to `attnLeft` and bit 8 goes to `loadLeft`.
- R3: A committed word with bits 10:9 = 2'b01 loads the right channel. Bits 7:0 go to `attnRight` and bit 8 goes to `loadRight`.
- R4: A committed word with bits 10:9 = 2'b10 writes the general controls: bit 0 to `softMute`, bit 1 to `deemphOn`, bit 2 to `dacOff`, and bits 4:3 to `wordSel`. Bits 8:5 of such a word have no effect.
- R5: A committed word with bits 10:9 = 2'b11 writes the format and filter controls: bit 0 to `i2sFmt`, bit 1 to `lrPolarity`, bit 2 to `commonAttn`, bit 3 to `slowRolloff`, bit 4 to `invertOut`, bit 5 to `clkHalf`, bits 7:6 to `deemphRate` (01 = 48 kHz, 10 = 44.1 kHz, 11 = 32 kHz), and bit 8 to `zeroDetEn`.
- R6: A word whose closing latch edge finds `chipSelN` high changes no register.
- R7: A word closed after fewer than 16 shift-clock rising edges since the latch line last toggled is discarded.
- R8: A word closed after more than 16 shift-clock rising edges since the latch line last toggled is discarded.
- R9: Bits 15:11 of a word are ignored. Setting them does not change the register that is written or the values written to it.
- R10: A committed word changes only the register its address selects. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| latchIn | input | 1 | Latch line; falling edge opens a word, rising edge commits it |
| shiftClkIn | input | 1 | Shift clock; data sampled on its rising edge |
| dataIn | input | 1 | Serial data, MSB first |
| chipSelN | input | 1 | Active-low select; writes only while low |
| attnLeft | output | 8 | Left attenuation code |
| loadLeft | output | 1 | Left attenuation load bit |
| attnRight | output | 8 | Right attenuation code |
| loadRight | output | 1 | Right attenuation load bit |
| softMute | output | 1 | Soft mute request |
| deemphOn | output | 1 | De-emphasis enable |
| dacOff | output | 1 | Converter operation off |
| wordSel | output | 2 | Input word length and format select |
| zeroDetEn | output | 1 | Zero-detect mute enable |
| deemphRate | output | 2 | De-emphasis sample-rate select |
| clkHalf | output | 1 | Clock output at half rate |
| invertOut | output | 1 | Output phase inversion |
| slowRolloff | output | 1 | Slow roll-off filter select |
| commonAttn | output | 1 | Left attenuation applies to both channels |
| lrPolarity | output | 1 | Frame-clock polarity select |
| i2sFmt | output | 1 | I2S format select |

## Verification
A pin edge passes two synchronizer flops and one edge-detect flop, so a commit reaches the outputs on the third system-clock edge after the latch line rises. Each shift edge is captured on the same schedule. The bench holds every shift-clock phase for three system clocks and keeps the data line stable across the whole high phase. After raising the latch line it waits six clocks, and it samples only on falling clock edges. All four register views are then compared against a shadow model, so every write, and every rejected write, is also checked against the registers it must not touch.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  // strobes sent from the framing control to the register datapath
  typedef struct packed {
    logic shiftEn;   // one serial bit is valid this cycle
    logic shiftBit;  // its value
    logic commit;    // a complete, selected word must be written
  } strobe_t;

  localparam logic [1:0] ADDR_LEFT  = 2'b00;
  localparam logic [1:0] ADDR_RIGHT = 2'b01;
  localparam logic [1:0] ADDR_GEN   = 2'b10;
  localparam logic [1:0] ADDR_FMT   = 2'b11;

  localparam logic [1:0] RATE_DEFAULT = 2'b10;
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stageQ[s] <= '0;
        else        stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stageQ[s] <= '0;
        else        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/ctrl_frame.sv
module ctrl_frame
  import ctrl_port_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    latchIn,
  input  logic    shiftClkIn,
  input  logic    dataIn,
  input  logic    chipSelN,
  output strobe_t strobes
);
  localparam int CNT_W = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_BITS + 1);

  logic latchS, shiftClkS, dataS, csS;
  logic latchPrev, shiftClkPrev;
  logic latchEdge, latchRise, shiftRise;
  logic [CNT_W-1:0] bitCount;

  ctrl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn({latchIn, shiftClkIn, dataIn, chipSelN}),
    .syncOut({latchS, shiftClkS, dataS, csS})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchPrev    <= 1'b0;
      shiftClkPrev <= 1'b0;
    end else begin
      latchPrev    <= latchS;
      shiftClkPrev <= shiftClkS;
    end
  end

  assign latchEdge = latchS ^ latchPrev;
  assign latchRise = latchS & ~latchPrev;
  assign shiftRise = shiftClkS & ~shiftClkPrev;

  // counter restarts on either latch edge and saturates one past a full word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               bitCount <= '0;
    else if (latchEdge)                       bitCount <= '0;
    else if (shiftRise && bitCount != CNT_OVER) bitCount <= bitCount + 1'b1;
  end

  always_comb begin
    strobes.shiftEn  = shiftRise;
    strobes.shiftBit = dataS;
    strobes.commit   = latchRise && (bitCount == CNT_FULL) && !csS;
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitCount <= CNT_OVER);

  // R7
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latchEdge |=> bitCount == '0);
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import ctrl_port_pkg::*;
#(
  parameter int ATTN_W   = 8,
  parameter int ADDR_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  output logic [ATTN_W-1:0] attnLeft,
  output logic              loadLeft,
  output logic [ATTN_W-1:0] attnRight,
  output logic              loadRight,
  output logic              softMute,
  output logic              deemphOn,
  output logic              dacOff,
  output logic [1:0]        wordSel,
  output logic              zeroDetEn,
  output logic [1:0]        deemphRate,
  output logic              clkHalf,
  output logic              invertOut,
  output logic              slowRolloff,
  output logic              commonAttn,
  output logic              lrPolarity,
  output logic              i2sFmt
);
  // only the address and the field bits are kept; older bits fall off the top
  localparam int KEEP_W   = ADDR_LSB + 2;
  localparam int LOAD_BIT = ATTN_W;

  logic [KEEP_W-1:0] shiftReg;
  logic [1:0]        wordAddr;
  logic [ATTN_W-1:0] attnQ [2];
  logic [1:0]        loadQ;
  logic [4:0]        genQ;
  logic [8:0]        fmtQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[KEEP_W-2:0], strobes.shiftBit};
  end

  assign wordAddr = shiftReg[ADDR_LSB +: 2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        attnQ[ch] <= '1;
        loadQ[ch] <= 1'b0;
      end else if (strobes.commit && wordAddr == 2'(ch)) begin
        attnQ[ch] <= shiftReg[ATTN_W-1:0];
        loadQ[ch] <= shiftReg[LOAD_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      genQ <= '0;
    else if (strobes.commit && wordAddr == ADDR_GEN) genQ <= shiftReg[4:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      fmtQ <= {1'b0, RATE_DEFAULT, 6'b0};
    else if (strobes.commit && wordAddr == ADDR_FMT) fmtQ <= shiftReg[8:0];
  end

  assign attnLeft    = attnQ[0];
  assign loadLeft    = loadQ[0];
  assign attnRight   = attnQ[1];
  assign loadRight   = loadQ[1];
  assign softMute    = genQ[0];
  assign deemphOn    = genQ[1];
  assign dacOff      = genQ[2];
  assign wordSel     = genQ[4:3];
  assign i2sFmt      = fmtQ[0];
  assign lrPolarity  = fmtQ[1];
  assign commonAttn  = fmtQ[2];
  assign slowRolloff = fmtQ[3];
  assign invertOut   = fmtQ[4];
  assign clkHalf     = fmtQ[5];
  assign deemphRate  = fmtQ[7:6];
  assign zeroDetEn   = fmtQ[8];

  // R6
  hold_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.commit |=> $stable({attnLeft, loadLeft, attnRight, loadRight,
                                 genQ, fmtQ}));

  // R2
  left_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.commit && wordAddr == ADDR_LEFT) |=>
      attnLeft == $past(shiftReg[ATTN_W-1:0]) && loadLeft == $past(shiftReg[LOAD_BIT]));

  // R5
  rate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.commit && wordAddr == ADDR_FMT) |=> deemphRate == $past(shiftReg[7:6]));

  // R10
  right_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.commit && wordAddr != ADDR_RIGHT) |=> $stable({attnRight, loadRight}));
endmodule

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port
  import ctrl_port_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ATTN_W      = 8,
  parameter int ADDR_LSB    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latchIn,
  input  logic              shiftClkIn,
  input  logic              dataIn,
  input  logic              chipSelN,
  output logic [ATTN_W-1:0] attnLeft,
  output logic              loadLeft,
  output logic [ATTN_W-1:0] attnRight,
  output logic              loadRight,
  output logic              softMute,
  output logic              deemphOn,
  output logic              dacOff,
  output logic [1:0]        wordSel,
  output logic              zeroDetEn,
  output logic [1:0]        deemphRate,
  output logic              clkHalf,
  output logic              invertOut,
  output logic              slowRolloff,
  output logic              commonAttn,
  output logic              lrPolarity,
  output logic              i2sFmt
);
  strobe_t strobes;

  ctrl_frame #(.WORD_BITS(WORD_BITS), .SYNC_STAGES(SYNC_STAGES)) frame_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .latchIn   (latchIn),
    .shiftClkIn(shiftClkIn),
    .dataIn    (dataIn),
    .chipSelN  (chipSelN),
    .strobes   (strobes)
  );

  ctrl_regs #(.ATTN_W(ATTN_W), .ADDR_LSB(ADDR_LSB)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .attnLeft   (attnLeft),
    .loadLeft   (loadLeft),
    .attnRight  (attnRight),
    .loadRight  (loadRight),
    .softMute   (softMute),
    .deemphOn   (deemphOn),
    .dacOff     (dacOff),
    .wordSel    (wordSel),
    .zeroDetEn  (zeroDetEn),
    .deemphRate (deemphRate),
    .clkHalf    (clkHalf),
    .invertOut  (invertOut),
    .slowRolloff(slowRolloff),
    .commonAttn (commonAttn),
    .lrPolarity (lrPolarity),
    .i2sFmt     (i2sFmt)
  );
endmodule

// File: tb/ctrl_serial_port_tb_top.sv
module ctrl_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 10;

  // word, expected 9-bit view of the addressed register
  localparam logic [15:0] VEC_WORD [NVEC] = '{
    16'h0055, 16'h01A0, 16'h0233, 16'h03FF, 16'h041B,
    16'h05E4, 16'h06C5, 16'h077A, 16'hF8AA, 16'hFE5E};
  localparam logic [8:0] VEC_EXP [NVEC] = '{
    9'h055, 9'h1A0, 9'h033, 9'h1FF, 9'h01B,
    9'h004, 9'h0C5, 9'h17A, 9'h0AA, 9'h05E};
  localparam logic [8:0] RESET_VIEW [4] = '{9'h0FF, 9'h0FF, 9'h000, 9'h080};

  logic clk = 1'b0;
  logic rst_n, latchIn, shiftClkIn, dataIn, chipSelN;
  logic [7:0] attnLeft, attnRight;
  logic loadLeft, loadRight, softMute, deemphOn, dacOff;
  logic [1:0] wordSel, deemphRate;
  logic zeroDetEn, clkHalf, invertOut, slowRolloff, commonAttn, lrPolarity, i2sFmt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [8:0] shadow [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .latchIn(latchIn), .shiftClkIn(shiftClkIn),
    .dataIn(dataIn), .chipSelN(chipSelN),
    .attnLeft(attnLeft), .loadLeft(loadLeft), .attnRight(attnRight),
    .loadRight(loadRight), .softMute(softMute), .deemphOn(deemphOn),
    .dacOff(dacOff), .wordSel(wordSel), .zeroDetEn(zeroDetEn),
    .deemphRate(deemphRate), .clkHalf(clkHalf), .invertOut(invertOut),
    .slowRolloff(slowRolloff), .commonAttn(commonAttn),
    .lrPolarity(lrPolarity), .i2sFmt(i2sFmt));

  function automatic logic [8:0] view(input int a);
    case (a)
      0:       return {loadLeft, attnLeft};
      1:       return {loadRight, attnRight};
      2:       return {4'b0, wordSel, dacOff, deemphOn, softMute};
      default: return {zeroDetEn, deemphRate, clkHalf, invertOut,
                       slowRolloff, commonAttn, lrPolarity, i2sFmt};
    endcase
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkAll(input string req);
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      checks++;
      if (view(a) !== shadow[a]) begin
        fails++;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, a, view(a), shadow[a]);
      end
    end
  endtask

  task automatic sendWord(input logic [15:0] w, input int nBits, input logic csHigh);
    chipSelN = csHigh;
    waitClk(4);
    latchIn = 1'b0;
    waitClk(4);
    for (int i = 0; i < nBits; i++) begin
      dataIn = (i < 16) ? w[15-i] : 1'b0;
      waitClk(3);
      shiftClkIn = 1'b1;
      waitClk(3);
      shiftClkIn = 1'b0;
    end
    waitClk(3);
    latchIn = 1'b1;
    waitClk(6);
    chipSelN = 1'b0;
    waitClk(2);
  endtask

  task automatic applyReset();
    rst_n = 1'b0;
    waitClk(3);
    rst_n = 1'b1;
    waitClk(2);
    for (int a = 0; a < 4; a++) shadow[a] = RESET_VIEW[a];
  endtask

  initial begin
    latchIn = 1'b1; shiftClkIn = 1'b0; dataIn = 1'b0; chipSelN = 1'b0;
    applyReset();
    checkAll("R1 reset defaults");

    // R2 R3 R4 R5 R9 R10: table walk, every view compared after each word
    for (int v = 0; v < NVEC; v++) begin
      sendWord(VEC_WORD[v], 16, 1'b0);
      shadow[VEC_WORD[v][10:9]] = VEC_EXP[v];
      case (VEC_WORD[v][10:9])
        2'b00:   checkAll(v >= 8 ? "R9 reserved bits, left" : "R2 left write");
        2'b01:   checkAll("R3 right write");
        2'b10:   checkAll("R4 general controls");
        default: checkAll(v >= 8 ? "R9 reserved bits, fmt" : "R5 format controls");
      endcase
    end

    // R6: chip select high at the closing edge
    sendWord(16'h0011, 16, 1'b1);
    checkAll("R6 chip select high");
    sendWord(16'h0711, 16, 1'b1);
    checkAll("R6 chip select high fmt");

    // R7: one bit short
    sendWord(16'h0211, 15, 1'b0);
    checkAll("R7 short word");

    // R8: one bit too many
    sendWord(16'h0211, 17, 1'b0);
    checkAll("R8 long word");

    // a good word after the rejected ones still lands (R10 isolation)
    sendWord(16'h0244, 16, 1'b0);
    shadow[1] = 9'h044;
    checkAll("R10 write after rejects");

    // R1: reset after writes restores defaults
    applyReset();
    checkAll("R1 reset after writes");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule